// File: doc/BRIEF.md
# Pipeline Hazard Controller

This block resolves read-after-write hazards for a five-stage in-order integer pipeline. It holds the hazard-relevant control fields of the ID/EX stage register itself: source indices, destination index, register-write enable, load flag and store flag. It compares the execute-stage sources against the destinations arriving from the EX/MEM and MEM/WB stage registers and drives the two ALU operand multiplexer selects. It also drives a select that lets a store in the memory stage take its data from a load one stage ahead of it. Register reads happen only in decode and writes only in writeback, so write-after-read and write-after-write ordering cannot go wrong, and the block ignores them.

A load cannot hand its result to the instruction directly behind it in time for execute. In that case the block raises `stall` for one cycle. The surrounding pipeline uses `stall` to freeze the PC and the IF/ID register, and the block itself loads a bubble into its ID/EX fields. There is one exception: a store that needs the loaded value only as its data does not stall, because that value is forwarded later in the memory stage. The register file, ALU and memories are outside the block. Every pin is a plain control pin; there is no streaming interface, so no handshake or back-pressure applies.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the ID/EX outputs (`idex_we`, `idex_load`, `idex_store`, `idex_rd`) are 0, `stall` is 0 and both operand selects are 00.
- R2: An execute operand whose index equals `exmem_rd` selects code 10 (EX/MEM result) when `exmem_we` is 1, `exmem_load` is 0 and `exmem_rd` is not 0.
- R3: An execute operand whose index equals `memwb_rd` selects code 01 (MEM/WB result) when `memwb_we` is 1 and `memwb_rd` is not 0, unless R2 applies. A load result in MEM/WB forwards the same way. With no match the code is 00 (register file).
- R4: When EX/MEM and MEM/WB both qualify for the same operand, the select is 10 (the younger EX/MEM value wins).
- R5: A destination index of 0 never causes a forward, a stall or a store-data forward.
- R6: An older instruction whose write enable is 0 never causes a forward or a stall, even when its destination index matches.
- R7: `stall` is 1 in the same cycle when ID/EX holds a load (`idex_load`=1, `idex_we`=1, `idex_rd`≠0) and `id_rs1` equals `idex_rd`, or `id_rs2` equals `idex_rd` and `id_store` is 0.
- R8: After a cycle with `stall`=1, the ID/EX outputs hold a bubble: `idex_we`, `idex_load` and `idex_store` are 0 and `idex_rd` is 0.
- R9: A store (`id_store`=1) whose only dependence on the preceding load is its data source `id_rs2` does not stall. When that store is in execute, the operand-B select never picks EX/MEM while `exmem_load` is 1.
- R10: `store_data_fwd` is 1 when `exmem_store` is 1, `memwb_we` and `memwb_load` are 1, `memwb_rd` is not 0 and `memwb_rd` equals `exmem_data_reg`. Otherwise it is 0.
- R11: In a cycle without a stall, the ID/EX fields take the decode inputs at the clock edge, and the outputs show them in the following cycle.
- R12: A load-use stall lasts exactly one cycle. With the same decode inputs held, `stall` is 0 in the cycle after the bubble is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_rs1 | input | IDX_W | Decode source 1 index |
| id_rs2 | input | IDX_W | Decode source 2 index (data source for stores) |
| id_rd | input | IDX_W | Decode destination index |
| id_we | input | 1 | Decode instruction writes a register |
| id_load | input | 1 | Decode instruction is a load |
| id_store | input | 1 | Decode instruction is a store |
| exmem_rd | input | IDX_W | EX/MEM destination index |
| exmem_we | input | 1 | EX/MEM register-write enable |
| exmem_load | input | 1 | EX/MEM holds a load |
| exmem_store | input | 1 | EX/MEM holds a store |
| exmem_data_reg | input | IDX_W | Data source index of the store in EX/MEM |
| memwb_rd | input | IDX_W | MEM/WB destination index |
| memwb_we | input | 1 | MEM/WB register-write enable |
| memwb_load | input | 1 | MEM/WB holds a load |
| stall | output | 1 | Freeze PC and IF/ID; bubble into ID/EX |
| fwd_a_sel | output | 2 | ALU operand A source: 00 reg file, 01 MEM/WB, 10 EX/MEM |
| fwd_b_sel | output | 2 | ALU operand B source, same coding |
| store_data_fwd | output | 1 | Memory-stage store data taken from MEM/WB load |
| idex_we | output | 1 | ID/EX write enable (0 in a bubble) |
| idex_load | output | 1 | ID/EX load flag (0 in a bubble) |
| idex_store | output | 1 | ID/EX store flag (0 in a bubble) |
| idex_rd | output | IDX_W | ID/EX destination index (0 in a bubble) |

## Verification
The bench targets operand priority when both older stages name the same register. A design that preferred MEM/WB there would feed a stale value and report 01 where 10 is expected. It drives destination 0 and cleared write enables with matching indices, and a design that compared indices alone would forward or stall spuriously. The load-then-store cases are checked from both sides. A store waiting on load data must not stall and must not pick the load's address from EX/MEM, while a store whose address depends on the load must stall. A missing bubble, or a stall that sticks, shows up as nonzero ID/EX enables or a second stall cycle.

// File: rtl/hzc_pkg.sv
package hzc_pkg;
  // ALU operand source code; the datapath mux decodes these values
  typedef enum logic [1:0] {
    SRC_RF    = 2'b00,
    SRC_MEMWB = 2'b01,
    SRC_EXMEM = 2'b10
  } opsrc_e;

  typedef struct packed {
    logic wr_en;
    logic is_load;
    logic is_store;
  } stage_ctl_t;
endpackage

// File: rtl/hzc_src_select.sv
module hzc_src_select
  import hzc_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] src_idx,
  input  logic [IDX_W-1:0] exmem_rd,
  input  logic             exmem_we,
  input  logic             exmem_load,
  input  logic [IDX_W-1:0] memwb_rd,
  input  logic             memwb_we,
  output opsrc_e           sel
);
  logic near_hit, far_hit;

  // EX/MEM of a load carries an address, not data: never bypass it
  assign near_hit = exmem_we && !exmem_load && (exmem_rd != '0) && (exmem_rd == src_idx);
  assign far_hit  = memwb_we && (memwb_rd != '0) && (memwb_rd == src_idx);

  always_comb begin
    sel = SRC_RF;
    if (far_hit)  sel = SRC_MEMWB;
    if (near_hit) sel = SRC_EXMEM; // younger result wins
  end

  assert_zero_src_from_rf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_idx == '0) |-> (sel == SRC_RF));

  assert_no_bypass_of_load_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exmem_load |-> (sel != SRC_EXMEM));
endmodule

// File: rtl/hzc_load_interlock.sv
module hzc_load_interlock #(
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] id_rs1,
  input  logic [IDX_W-1:0] id_rs2,
  input  logic             id_store,
  input  logic [IDX_W-1:0] ex_rd,
  input  logic             ex_we,
  input  logic             ex_load,
  output logic             stall
);
  logic load_live, use_addr, use_data;

  assign load_live = ex_we && ex_load && (ex_rd != '0);
  assign use_addr  = (id_rs1 == ex_rd);
  // store data is forwarded in the memory stage, so it does not interlock
  assign use_data  = (id_rs2 == ex_rd) && !id_store;
  assign stall     = load_live && (use_addr || use_data);

  assert_stall_only_behind_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (ex_load && ex_we));
endmodule

// File: rtl/hzc_idex_ctl.sv
module hzc_idex_ctl
  import hzc_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bubble,
  input  logic [IDX_W-1:0] in_rs1,
  input  logic [IDX_W-1:0] in_rs2,
  input  logic [IDX_W-1:0] in_rd,
  input  stage_ctl_t       in_ctl,
  output logic [IDX_W-1:0] q_rs1,
  output logic [IDX_W-1:0] q_rs2,
  output logic [IDX_W-1:0] q_rd,
  output stage_ctl_t       q_ctl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_rs1 <= '0;
      q_rs2 <= '0;
      q_rd  <= '0;
      q_ctl <= '0;
    end else if (bubble) begin
      q_rs1 <= '0;
      q_rs2 <= '0;
      q_rd  <= '0;
      q_ctl <= '0;
    end else begin
      q_rs1 <= in_rs1;
      q_rs2 <= in_rs2;
      q_rd  <= in_rd;
      q_ctl <= in_ctl;
    end
  end

  assert_bubble_clears_ctl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bubble |=> (q_ctl == '0 && q_rd == '0));
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
  import hzc_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] id_rs1,
  input  logic [IDX_W-1:0] id_rs2,
  input  logic [IDX_W-1:0] id_rd,
  input  logic             id_we,
  input  logic             id_load,
  input  logic             id_store,
  input  logic [IDX_W-1:0] exmem_rd,
  input  logic             exmem_we,
  input  logic             exmem_load,
  input  logic             exmem_store,
  input  logic [IDX_W-1:0] exmem_data_reg,
  input  logic [IDX_W-1:0] memwb_rd,
  input  logic             memwb_we,
  input  logic             memwb_load,
  output logic             stall,
  output logic [1:0]       fwd_a_sel,
  output logic [1:0]       fwd_b_sel,
  output logic             store_data_fwd,
  output logic             idex_we,
  output logic             idex_load,
  output logic             idex_store,
  output logic [IDX_W-1:0] idex_rd
);
  localparam int unsigned NUM_SRC = 2;

  stage_ctl_t       dec_ctl, ex_ctl;
  logic [IDX_W-1:0] ex_rs1, ex_rs2, ex_rd;
  logic [IDX_W-1:0] ex_src [NUM_SRC];
  opsrc_e           op_sel [NUM_SRC];

  assign dec_ctl = '{wr_en: id_we, is_load: id_load, is_store: id_store};

  hzc_idex_ctl #(.IDX_W(IDX_W)) u_idex (
    .clk(clk), .rst_n(rst_n), .bubble(stall),
    .in_rs1(id_rs1), .in_rs2(id_rs2), .in_rd(id_rd), .in_ctl(dec_ctl),
    .q_rs1(ex_rs1), .q_rs2(ex_rs2), .q_rd(ex_rd), .q_ctl(ex_ctl)
  );

  hzc_load_interlock #(.IDX_W(IDX_W)) u_interlock (
    .clk(clk), .rst_n(rst_n),
    .id_rs1(id_rs1), .id_rs2(id_rs2), .id_store(id_store),
    .ex_rd(ex_rd), .ex_we(ex_ctl.wr_en), .ex_load(ex_ctl.is_load),
    .stall(stall)
  );

  assign ex_src[0] = ex_rs1;
  assign ex_src[1] = ex_rs2;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_opsel
    hzc_src_select #(.IDX_W(IDX_W)) u_sel (
      .clk(clk), .rst_n(rst_n), .src_idx(ex_src[g]),
      .exmem_rd(exmem_rd), .exmem_we(exmem_we), .exmem_load(exmem_load),
      .memwb_rd(memwb_rd), .memwb_we(memwb_we), .sel(op_sel[g])
    );
  end

  assign fwd_a_sel = op_sel[0];
  assign fwd_b_sel = op_sel[1];

  // load in writeback feeding the store data directly behind it
  assign store_data_fwd = exmem_store && memwb_we && memwb_load &&
                          (memwb_rd != '0) && (memwb_rd == exmem_data_reg);

  assign idex_we    = ex_ctl.wr_en;
  assign idex_load  = ex_ctl.is_load;
  assign idex_store = ex_ctl.is_store;
  assign idex_rd    = ex_rd;

  assert_single_cycle_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);

  assert_store_fwd_zero_dest_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (memwb_rd == '0) |-> !store_data_fwd);
endmodule

// File: tb/test_pipe_hazard_ctrl.sv
module test_pipe_hazard_ctrl;
  localparam int W = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [W-1:0] id_rs1, id_rs2, id_rd, exmem_rd, exmem_data_reg, memwb_rd;
  logic id_we, id_load, id_store, exmem_we, exmem_load, exmem_store, memwb_we, memwb_load;
  logic stall, store_data_fwd, idex_we, idex_load, idex_store;
  logic [1:0] fwd_a_sel, fwd_b_sel;
  logic [W-1:0] idex_rd;

  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk; // 125 MHz

  pipe_hazard_ctrl #(.IDX_W(W)) i_pipe_hazard_ctrl (.*);

  typedef struct packed {
    logic [4:0] p_rs1, p_rs2, p_rd; logic p_we, p_ld, p_st;
    logic [4:0] i_rs1, i_rs2; logic i_st;
    logic [4:0] x_rd; logic x_we, x_ld, x_st; logic [4:0] x_dr;
    logic [4:0] m_rd; logic m_we, m_ld;
    logic e_stall; logic [1:0] e_a, e_b; logic e_sf;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    // R2: operand A from EX/MEM
    '{5'd3,5'd4,5'd9,1'b1,1'b0,1'b0, 5'd0,5'd0,1'b0, 5'd3,1'b1,1'b0,1'b0,5'd0, 5'd0,1'b0,1'b0, 1'b0,2'b10,2'b00,1'b0},
    // R3: operand B from MEM/WB
    '{5'd5,5'd6,5'd9,1'b1,1'b0,1'b0, 5'd0,5'd0,1'b0, 5'd0,1'b0,1'b0,1'b0,5'd0, 5'd6,1'b1,1'b0, 1'b0,2'b00,2'b01,1'b0},
    // R4: both stages match, EX/MEM wins
    '{5'd7,5'd7,5'd9,1'b1,1'b0,1'b0, 5'd0,5'd0,1'b0, 5'd7,1'b1,1'b0,1'b0,5'd0, 5'd7,1'b1,1'b0, 1'b0,2'b10,2'b10,1'b0},
    // R5: destination zero never forwards
    '{5'd0,5'd0,5'd9,1'b1,1'b0,1'b0, 5'd0,5'd0,1'b0, 5'd0,1'b1,1'b0,1'b0,5'd0, 5'd0,1'b1,1'b0, 1'b0,2'b00,2'b00,1'b0},
    // R6: write enable low never forwards
    '{5'd8,5'd8,5'd9,1'b1,1'b0,1'b0, 5'd0,5'd0,1'b0, 5'd8,1'b0,1'b0,1'b0,5'd0, 5'd8,1'b0,1'b0, 1'b0,2'b00,2'b00,1'b0},
    // R2/R3: split sources
    '{5'd1,5'd2,5'd9,1'b1,1'b0,1'b0, 5'd0,5'd0,1'b0, 5'd2,1'b1,1'b0,1'b0,5'd0, 5'd1,1'b1,1'b0, 1'b0,2'b01,2'b10,1'b0},
    // R7: load-use on rs1
    '{5'd0,5'd0,5'd10,1'b1,1'b1,1'b0, 5'd10,5'd0,1'b0, 5'd0,1'b0,1'b0,1'b0,5'd0, 5'd0,1'b0,1'b0, 1'b1,2'b00,2'b00,1'b0},
    // R7: load-use on rs2 of non-store
    '{5'd0,5'd0,5'd11,1'b1,1'b1,1'b0, 5'd0,5'd11,1'b0, 5'd0,1'b0,1'b0,1'b0,5'd0, 5'd0,1'b0,1'b0, 1'b1,2'b00,2'b00,1'b0},
    // R9: store data after load, no stall
    '{5'd0,5'd0,5'd12,1'b1,1'b1,1'b0, 5'd3,5'd12,1'b1, 5'd0,1'b0,1'b0,1'b0,5'd0, 5'd0,1'b0,1'b0, 1'b0,2'b00,2'b00,1'b0},
    // R7: store address after load stalls
    '{5'd0,5'd0,5'd12,1'b1,1'b1,1'b0, 5'd12,5'd4,1'b1, 5'd0,1'b0,1'b0,1'b0,5'd0, 5'd0,1'b0,1'b0, 1'b1,2'b00,2'b00,1'b0},
    // R5: load to register zero never stalls
    '{5'd0,5'd0,5'd0,1'b1,1'b1,1'b0, 5'd0,5'd0,1'b0, 5'd0,1'b0,1'b0,1'b0,5'd0, 5'd0,1'b0,1'b0, 1'b0,2'b00,2'b00,1'b0},
    // R6: load with write enable low never stalls
    '{5'd0,5'd0,5'd13,1'b0,1'b1,1'b0, 5'd13,5'd0,1'b0, 5'd0,1'b0,1'b0,1'b0,5'd0, 5'd0,1'b0,1'b0, 1'b0,2'b00,2'b00,1'b0},
    // R10: store data from MEM/WB load
    '{5'd0,5'd0,5'd0,1'b0,1'b0,1'b0, 5'd0,5'd0,1'b0, 5'd0,1'b0,1'b0,1'b1,5'd14, 5'd14,1'b1,1'b1, 1'b0,2'b00,2'b00,1'b1},
    // R10: non-load in MEM/WB does not forward store data
    '{5'd0,5'd0,5'd0,1'b0,1'b0,1'b0, 5'd0,5'd0,1'b0, 5'd0,1'b0,1'b0,1'b1,5'd14, 5'd14,1'b1,1'b0, 1'b0,2'b00,2'b00,1'b0},
    // R9: store in EX never takes load address from EX/MEM
    '{5'd0,5'd15,5'd0,1'b0,1'b0,1'b1, 5'd0,5'd0,1'b0, 5'd15,1'b1,1'b1,1'b0,5'd0, 5'd0,1'b0,1'b0, 1'b0,2'b00,2'b00,1'b0},
    // R5: store-data forward from register zero suppressed
    '{5'd0,5'd0,5'd0,1'b0,1'b0,1'b0, 5'd0,5'd0,1'b0, 5'd0,1'b0,1'b0,1'b1,5'd0, 5'd0,1'b1,1'b1, 1'b0,2'b00,2'b00,1'b0},
    // R3: load result in MEM/WB forwards to ALU
    '{5'd16,5'd0,5'd9,1'b1,1'b0,1'b0, 5'd0,5'd0,1'b0, 5'd0,1'b0,1'b0,1'b0,5'd0, 5'd16,1'b1,1'b1, 1'b0,2'b01,2'b00,1'b0}
  };

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic clear_in();
    id_rs1 = '0; id_rs2 = '0; id_rd = '0; id_we = 0; id_load = 0; id_store = 0;
    exmem_rd = '0; exmem_we = 0; exmem_load = 0; exmem_store = 0; exmem_data_reg = '0;
    memwb_rd = '0; memwb_we = 0; memwb_load = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    clear_in();
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk("R1 stall in reset", stall, 0);
    chk("R1 idex_we in reset", idex_we, 0);
    chk("R1 fwd_a in reset", fwd_a_sel, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idex_rd after reset", idex_rd, 0);
    chk("R1 fwd_b after reset", fwd_b_sel, 0);

    for (int v = 0; v < NV; v++) begin
      clear_in();
      @(negedge clk);
      id_rs1 = VECS[v].p_rs1; id_rs2 = VECS[v].p_rs2; id_rd = VECS[v].p_rd;
      id_we = VECS[v].p_we; id_load = VECS[v].p_ld; id_store = VECS[v].p_st;
      @(negedge clk);
      clear_in();
      id_rs1 = VECS[v].i_rs1; id_rs2 = VECS[v].i_rs2; id_store = VECS[v].i_st;
      exmem_rd = VECS[v].x_rd; exmem_we = VECS[v].x_we; exmem_load = VECS[v].x_ld;
      exmem_store = VECS[v].x_st; exmem_data_reg = VECS[v].x_dr;
      memwb_rd = VECS[v].m_rd; memwb_we = VECS[v].m_we; memwb_load = VECS[v].m_ld;
      #1;
      chk($sformatf("vector %0d stall", v), stall, VECS[v].e_stall);
      chk($sformatf("vector %0d fwd_a", v), fwd_a_sel, VECS[v].e_a);
      chk($sformatf("vector %0d fwd_b", v), fwd_b_sel, VECS[v].e_b);
      chk($sformatf("vector %0d store_fwd", v), store_data_fwd, VECS[v].e_sf);
      @(negedge clk);
      clear_in();
    end

    // R11: decode fields captured when not stalled
    @(negedge clk);
    clear_in();
    id_rd = 5'd5; id_we = 1; id_load = 1;
    @(negedge clk);
    chk("R11 idex_we", idex_we, 1);
    chk("R11 idex_load", idex_load, 1);
    chk("R11 idex_rd", idex_rd, 5);
    // R7: dependent instruction right behind the load
    id_rs1 = 5'd5; id_rd = 5'd6; id_we = 1; id_load = 0;
    #1;
    chk("R7 load-use stall", stall, 1);
    @(negedge clk);
    chk("R8 bubble idex_we", idex_we, 0);
    chk("R8 bubble idex_load", idex_load, 0);
    chk("R8 bubble idex_rd", idex_rd, 0);
    chk("R12 stall released", stall, 0);
    @(negedge clk);
    chk("R11 held instruction advances rd", idex_rd, 6);
    chk("R11 held instruction advances we", idex_we, 1);
    clear_in();
    id_store = 1; id_rs2 = 5'd7;
    @(negedge clk);
    chk("R11 idex_store", idex_store, 1);
    chk("R11 idex_we for store", idex_we, 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule